// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides, once per clock, whether a 32-bit RISC core with privileged modes takes an exception, returns from one, or does neither. It receives the raw exception requests (reset, undefined instruction, software interrupt, prefetch abort, data abort, IRQ, FIQ), a return request, the current status word and the return address that the pipeline has prepared. It also receives the saved status word and link value that the banked register file holds for the current mode. It then issues one coordinated set of write strobes. These strobes load the new status word, save the old status word and the link address into the bank of the target mode, and redirect the PC.

Every update for one event appears on the same clock edge, so the pipeline never sees a half-finished mode change. The vector address comes from an eight-slot table with four bytes per slot. A configuration input moves the base of this table from address zero to high memory. All interfaces are plain control and data pins with no back-pressure, because the core must accept a redirect on the cycle it is issued.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is active, and on every cycle with no request and no return, all four write strobes (`status_we`, `spsr_we`, `lr_we`, `pc_we`) are low.
- R2: When several unmasked requests are present at once, only one is taken, in this order from highest to lowest: reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R3: An IRQ request is ignored while status bit 7 (I) is 1. An FIQ request is ignored while status bit 6 (F) is 1. A lower-priority request that is unmasked is then taken instead.
- R4: With `high_vec` low, the PC is loaded with these vector addresses: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. Slot 0x14 is unused.
- R5: With `high_vec` high, the same offsets are added to base 0xFFFF0000.
- R6: On entry, the new status word keeps every bit of the old one except for these changes:
  - Bits 4:0 become the target mode: Supervisor 10011 for reset and software interrupt, Undefined 11011, Abort 10111 for both aborts, IRQ 10010, FIQ 10001. (User is 10000 and System is 11111.)
  - T (bit 5) and J (bit 24) are cleared.
  - I (bit 7) is set.
  - F (bit 6) is set for reset and FIQ, and left unchanged otherwise.
- R7: On entry other than reset, `spsr_data` carries the status word as it was before the entry, and `lr_data` carries `link_addr`. Both are written to the bank named by `bank_mode`, which equals the target mode.
- R8: A reset request enters Supervisor mode with I and F set. It does not write a saved status word or a link register (`spsr_we` and `lr_we` stay low).
- R9: An accepted return loads the status word from `saved_status_rd` and the PC from `link_rd`, with `spsr_we` and `lr_we` low.
- R10: A return is ignored when T or J is set, or when the current mode is User or System. A return that arrives together with any request that is taken is also ignored.
- R11: All strobes and data for one event appear together, registered, one clock after the edge that samples the request. Each strobe is a one-cycle pulse when the request lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| req_reset | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| ret_req | input | 1 | Return-from-exception request |
| high_vec | input | 1 | Selects the high vector base 0xFFFF0000 |
| cur_status | input | 32 | Current status word |
| link_addr | input | 32 | Return address to store on entry |
| saved_status_rd | input | 32 | Saved status word of the current mode |
| link_rd | input | 32 | Link register of the current mode |
| status_we | output | 1 | Status word write strobe |
| status_new | output | 32 | New status word |
| bank_mode | output | 5 | Mode whose bank receives the saved status and link writes |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_data | output | 32 | Saved status value |
| lr_we | output | 1 | Link register write strobe |
| lr_data | output | 32 | Link value |
| pc_we | output | 1 | PC load strobe |
| pc_data | output | 32 | Vector or return address |

## Verification
Every result is due exactly one clock after the rising edge that samples the request: the registered strobes, the new status word, the saved copy, the link value and the PC target. The bench changes inputs only on the falling edge. It reads the outputs one nanosecond after the next rising edge, so the event just applied is the one being checked. It then clears the inputs and checks on the following cycle that every strobe has dropped. This confirms the one-cycle pulse and also confirms that masked or blocked requests leave nothing behind.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SLOT_W = 3;

  // Vector slot numbers double as exception kinds.
  localparam logic [SLOT_W-1:0] SLOT_RST  = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_UND  = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_SWI  = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_PABT = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_DABT = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_IRQ  = 3'd6;
  localparam logic [SLOT_W-1:0] SLOT_FIQ  = 3'd7;

  localparam int PRIO_LEN = 7;
  // Highest priority first.
  localparam logic [SLOT_W-1:0] PRIO_ORDER [PRIO_LEN] =
    '{SLOT_RST, SLOT_DABT, SLOT_FIQ, SLOT_IRQ, SLOT_PABT, SLOT_UND, SLOT_SWI};

  // Status word bit positions.
  localparam int SB_J = 24;
  localparam int SB_I = 7;
  localparam int SB_F = 6;
  localparam int SB_T = 5;
  localparam int MODE_W = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  function automatic logic [MODE_W-1:0] mode_for_slot(input logic [SLOT_W-1:0] s);
    case (s)
      SLOT_UND:            return MODE_UND;
      SLOT_PABT, SLOT_DABT: return MODE_ABT;
      SLOT_IRQ:            return MODE_IRQ;
      SLOT_FIQ:            return MODE_FIQ;
      default:             return MODE_SVC;
    endcase
  endfunction

  function automatic logic mode_has_bank(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: return 1'b1;
      default:                                          return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSLOT-1:0] req_slot,
  input  logic          irq_masked,
  input  logic          fiq_masked,
  output logic          grant_vld,
  output logic [SW-1:0] grant_slot
);
  logic [NSLOT-1:0] eff;

  always_comb begin
    eff = req_slot;
    if (irq_masked) eff[SLOT_IRQ] = 1'b0;
    if (fiq_masked) eff[SLOT_FIQ] = 1'b0;
  end

  // Scan lowest priority first so the highest pending one wins.
  always_comb begin
    grant_vld  = 1'b0;
    grant_slot = '0;
    for (int p = PRIO_LEN - 1; p >= 0; p--) begin
      if (eff[PRIO_ORDER[p]]) begin
        grant_vld  = 1'b1;
        grant_slot = SW'(PRIO_ORDER[p]);
      end
    end
  end

  a_r2_grant_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> eff[grant_slot]);
  a_r1_no_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == '0) |-> !grant_vld);
  a_r3_masked_irq_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
    irq_masked |-> !(grant_vld && grant_slot == SW'(SLOT_IRQ)));
  a_r3_masked_fiq_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_masked |-> !(grant_vld && grant_slot == SW'(SLOT_FIQ)));
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int XW = 32,
  parameter int NSLOT = 8,
  parameter int SLOT_BYTES = 4,
  parameter logic [XW-1:0] HI_BASE = 32'hFFFF_0000,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          high_sel,
  input  logic [SW-1:0] slot,
  output logic [XW-1:0] vec_addr
);
  logic [XW-1:0] offs [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign offs[g] = XW'(g * SLOT_BYTES);
  end

  assign vec_addr = (high_sel ? HI_BASE : '0) + offs[slot];
endmodule

// File: rtl/exc_status_build.sv
module exc_status_build
  import exc_pkg::*;
#(
  parameter int XW = 32
) (
  input  logic [XW-1:0]     cur,
  input  logic [SLOT_W-1:0] slot,
  output logic [XW-1:0]     nxt,
  output logic [MODE_W-1:0] tgt_mode
);
  always_comb begin
    tgt_mode = mode_for_slot(slot);
    nxt = cur;
    nxt[MODE_W-1:0] = tgt_mode;
    nxt[SB_T] = 1'b0;
    nxt[SB_J] = 1'b0;
    nxt[SB_I] = 1'b1;
    if (slot == SLOT_RST || slot == SLOT_FIQ) nxt[SB_F] = 1'b1;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XW = 32,
  parameter int NSLOT = 8,
  parameter int SLOT_BYTES = 4,
  parameter logic [XW-1:0] HI_BASE = 32'hFFFF_0000,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_reset,
  input  logic          req_und,
  input  logic          req_swi,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          req_irq,
  input  logic          req_fiq,
  input  logic          ret_req,
  input  logic          high_vec,
  input  logic [XW-1:0] cur_status,
  input  logic [XW-1:0] link_addr,
  input  logic [XW-1:0] saved_status_rd,
  input  logic [XW-1:0] link_rd,
  output logic          status_we,
  output logic [XW-1:0] status_new,
  output logic [MODE_W-1:0] bank_mode,
  output logic          spsr_we,
  output logic [XW-1:0] spsr_data,
  output logic          lr_we,
  output logic [XW-1:0] lr_data,
  output logic          pc_we,
  output logic [XW-1:0] pc_data
);
  logic [NSLOT-1:0]  req_slot;
  logic              grant_vld;
  logic [SW-1:0]     grant_slot;
  logic [XW-1:0]     vec_addr;
  logic [XW-1:0]     built;
  logic [MODE_W-1:0] tgt_mode;
  logic              take_exc, take_ret, is_rst;
  logic              past_ok;

  always_comb begin
    req_slot = '0;
    req_slot[SLOT_RST]  = req_reset;
    req_slot[SLOT_UND]  = req_und;
    req_slot[SLOT_SWI]  = req_swi;
    req_slot[SLOT_PABT] = req_pabt;
    req_slot[SLOT_DABT] = req_dabt;
    req_slot[SLOT_IRQ]  = req_irq;
    req_slot[SLOT_FIQ]  = req_fiq;
  end

  exc_arbiter #(.NSLOT(NSLOT)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_slot(req_slot),
    .irq_masked(cur_status[SB_I]), .fiq_masked(cur_status[SB_F]),
    .grant_vld(grant_vld), .grant_slot(grant_slot)
  );

  exc_vector #(.XW(XW), .NSLOT(NSLOT), .SLOT_BYTES(SLOT_BYTES), .HI_BASE(HI_BASE)) u_vec (
    .high_sel(high_vec), .slot(grant_slot), .vec_addr(vec_addr)
  );

  exc_status_build #(.XW(XW)) u_build (
    .cur(cur_status), .slot(SLOT_W'(grant_slot)), .nxt(built), .tgt_mode(tgt_mode)
  );

  assign take_exc = grant_vld;
  assign is_rst   = grant_slot == SW'(SLOT_RST);
  assign take_ret = ret_req && !grant_vld && !cur_status[SB_T] && !cur_status[SB_J]
                    && mode_has_bank(cur_status[MODE_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_we  <= 1'b0;
      status_new <= '0;
      bank_mode  <= '0;
      spsr_we    <= 1'b0;
      spsr_data  <= '0;
      lr_we      <= 1'b0;
      lr_data    <= '0;
      pc_we      <= 1'b0;
      pc_data    <= '0;
      past_ok    <= 1'b0;
    end else begin
      past_ok   <= 1'b1;
      status_we <= take_exc || take_ret;
      pc_we     <= take_exc || take_ret;
      spsr_we   <= take_exc && !is_rst;
      lr_we     <= take_exc && !is_rst;
      if (take_exc) begin
        status_new <= built;
        pc_data    <= vec_addr;
        bank_mode  <= tgt_mode;
        spsr_data  <= cur_status;
        lr_data    <= link_addr;
      end else if (take_ret) begin
        status_new <= saved_status_rd;
        pc_data    <= link_rd;
        bank_mode  <= cur_status[MODE_W-1:0];
      end
    end
  end

  a_r11_entry_is_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (lr_we && status_we && pc_we));
  a_r7_saved_before_change: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && spsr_we) |-> (spsr_data == $past(cur_status)));
  a_r7_link_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lr_we) |-> (lr_data == $past(link_addr)));
  a_r6_state_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (status_we && lr_we) |-> (!status_new[SB_T] && !status_new[SB_J] && status_new[SB_I]));
  a_r5_vector_base: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lr_we) |-> (pc_data[XW-1:8] == ($past(high_vec) ? HI_BASE[XW-1:8] : '0)));
  a_r9_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pc_we && !lr_we && !$past(req_reset))
      |-> (pc_data == $past(link_rd) && status_new == $past(saved_status_rd)));
  a_r10_no_return_in_thumb: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_slot == '0) && $past(cur_status[SB_T])) |-> !status_we);
  a_r8_reset_no_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_reset)) |-> (!spsr_we && !lr_we && status_new[SB_F]));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  localparam logic [6:0] Q_RST = 7'h01, Q_UND = 7'h02, Q_SWI = 7'h04, Q_PABT = 7'h08,
                         Q_DABT = 7'h10, Q_IRQ = 7'h20, Q_FIQ = 7'h40;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011, M_SYS = 5'b11111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_reset, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq, ret_req, high_vec;
  logic [31:0] cur_status, link_addr, saved_status_rd, link_rd;
  logic status_we, spsr_we, lr_we, pc_we;
  logic [31:0] status_new, spsr_data, lr_data, pc_data;
  logic [4:0] bank_mode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_und(req_und), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .ret_req(ret_req), .high_vec(high_vec), .cur_status(cur_status), .link_addr(link_addr),
    .saved_status_rd(saved_status_rd), .link_rd(link_rd), .status_we(status_we),
    .status_new(status_new), .bank_mode(bank_mode), .spsr_we(spsr_we), .spsr_data(spsr_data),
    .lr_we(lr_we), .lr_data(lr_data), .pc_we(pc_we), .pc_data(pc_data)
  );

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] flags, input bit j, input bit i,
                                     input bit f, input bit t, input logic [4:0] m);
    logic [31:0] s = 32'h0001_0000;
    s[31:27] = flags; s[24] = j; s[7] = i; s[6] = f; s[5] = t; s[4:0] = m;
    return s;
  endfunction

  task automatic drive(input logic [6:0] rq, input bit ret, input bit hv, input logic [31:0] st,
                       input logic [31:0] la, input logic [31:0] srd, input logic [31:0] lrd);
    req_reset = rq[0]; req_und = rq[1]; req_swi = rq[2]; req_pabt = rq[3];
    req_dabt = rq[4]; req_irq = rq[5]; req_fiq = rq[6];
    ret_req = ret; high_vec = hv; cur_status = st; link_addr = la;
    saved_status_rd = srd; link_rd = lrd;
  endtask

  task automatic fire(input logic [6:0] rq, input bit ret, input bit hv, input logic [31:0] st,
                      input logic [31:0] la, input logic [31:0] srd, input logic [31:0] lrd);
    @(negedge clk);
    drive(rq, ret, hv, st, la, srd, lrd);
    @(posedge clk); #1;
  endtask

  // R11: strobes drop one cycle after a single-cycle request; R1 idle.
  task automatic idle_check(input string tag);
    @(negedge clk);
    drive(7'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    @(posedge clk); #1;
    ck({tag, " R11 R1 strobes low"}, {28'h0, status_we, spsr_we, lr_we, pc_we}, 32'h0);
  endtask

  task automatic entry(input string tag, input logic [6:0] rq, input bit hv, input logic [31:0] st,
                       input logic [4:0] ex_mode, input logic [31:0] ex_pc, input bit ex_f,
                       input bit ex_bank);
    logic [31:0] exp = st;
    logic [31:0] la = st ^ 32'h1234_5678;
    exp[4:0] = ex_mode; exp[5] = 1'b0; exp[24] = 1'b0; exp[7] = 1'b1;
    if (ex_f) exp[6] = 1'b1;
    fire(rq, 1'b0, hv, st, la, 32'hDEAD_0000, 32'hBEEF_0000);
    ck({tag, " R6 status_we"}, {31'h0, status_we}, 32'h1);
    ck({tag, " R6 status_new"}, status_new, exp);
    ck({tag, " R4 R5 pc"}, {31'h0, pc_we} ^ pc_data, 32'h1 ^ ex_pc);
    ck({tag, " R7 bank_mode"}, {27'h0, bank_mode}, {27'h0, ex_mode});
    ck({tag, " R7 R8 bank strobes"}, {30'h0, spsr_we, lr_we}, ex_bank ? 32'h3 : 32'h0);
    if (ex_bank) begin
      ck({tag, " R7 spsr_data"}, spsr_data, st);
      ck({tag, " R7 lr_data"}, lr_data, la);
    end
    idle_check(tag);
  endtask

  task automatic nothing(input string tag, input logic [6:0] rq, input bit ret, input logic [31:0] st);
    fire(rq, ret, 1'b0, st, 32'h0000_1000, 32'h5555_0013, 32'h0000_2000);
    ck({tag, " no strobes"}, {28'h0, status_we, spsr_we, lr_we, pc_we}, 32'h0);
    idle_check(tag);
  endtask

  task automatic t_reset_state();
    ck("R1 reset strobes", {28'h0, status_we, spsr_we, lr_we, pc_we}, 32'h0);
  endtask

  task automatic t_low_vectors();
    logic [31:0] u = mk(5'b10101, 0, 0, 0, 0, M_USR);
    entry("R4 R8 reset", Q_RST, 0, u, M_SVC, 32'h00, 1, 0);
    entry("R4 und", Q_UND, 0, u, M_UND, 32'h04, 0, 1);
    entry("R4 swi", Q_SWI, 0, u, M_SVC, 32'h08, 0, 1);
    entry("R4 pabt", Q_PABT, 0, u, M_ABT, 32'h0C, 0, 1);
    entry("R4 dabt", Q_DABT, 0, u, M_ABT, 32'h10, 0, 1);
    entry("R4 irq", Q_IRQ, 0, u, M_IRQ, 32'h18, 0, 1);
    entry("R4 fiq", Q_FIQ, 0, u, M_FIQ, 32'h1C, 1, 1);
  endtask

  task automatic t_high_vectors();
    logic [31:0] u = mk(5'b01010, 0, 0, 0, 0, M_USR);
    entry("R5 swi high", Q_SWI, 1, u, M_SVC, 32'hFFFF_0008, 0, 1);
    entry("R5 fiq high", Q_FIQ, 1, u, M_FIQ, 32'hFFFF_001C, 1, 1);
    entry("R5 reset high", Q_RST, 1, u, M_SVC, 32'hFFFF_0000, 1, 0);
  endtask

  task automatic t_priority();
    logic [31:0] u = mk(5'b11000, 0, 0, 0, 0, M_USR);
    entry("R2 all", 7'h7F, 0, u, M_SVC, 32'h00, 1, 0);
    entry("R2 dabt wins", Q_DABT | Q_FIQ | Q_IRQ | Q_PABT | Q_UND, 0, u, M_ABT, 32'h10, 0, 1);
    entry("R2 fiq wins", Q_FIQ | Q_IRQ | Q_PABT, 0, u, M_FIQ, 32'h1C, 1, 1);
    entry("R2 irq wins", Q_IRQ | Q_PABT | Q_UND, 0, u, M_IRQ, 32'h18, 0, 1);
    entry("R2 pabt wins", Q_PABT | Q_UND | Q_SWI, 0, u, M_ABT, 32'h0C, 0, 1);
    entry("R2 und over swi", Q_UND | Q_SWI, 0, u, M_UND, 32'h04, 0, 1);
  endtask

  task automatic t_masking();
    nothing("R3 irq masked", Q_IRQ, 0, mk(5'b0, 0, 1, 0, 0, M_USR));
    nothing("R3 fiq masked", Q_FIQ, 0, mk(5'b0, 0, 0, 1, 0, M_USR));
    entry("R3 pabt under masked irq", Q_IRQ | Q_PABT, 0, mk(5'b00001, 0, 1, 0, 0, M_USR),
          M_ABT, 32'h0C, 0, 1);
    entry("R3 irq under masked fiq", Q_FIQ | Q_IRQ, 0, mk(5'b00010, 0, 0, 1, 0, M_SVC),
          M_IRQ, 32'h18, 1, 1);
  endtask

  task automatic t_state_forced();
    entry("R6 thumb+j to swi", Q_SWI, 0, mk(5'b11111, 1, 0, 1, 1, M_SVC), M_SVC, 32'h08, 1, 1);
  endtask

  task automatic t_return();
    fire(7'h0, 1, 0, mk(5'b00100, 0, 1, 0, 0, M_IRQ), 32'h0, 32'h6000_0030, 32'h0000_8124);
    ck("R9 return status_we", {31'h0, status_we}, 32'h1);
    ck("R9 return status", status_new, 32'h6000_0030);
    ck("R9 return pc", pc_data, 32'h0000_8124);
    ck("R9 return pc_we", {31'h0, pc_we}, 32'h1);
    ck("R9 return no bank writes", {30'h0, spsr_we, lr_we}, 32'h0);
    idle_check("R9");
  endtask

  task automatic t_return_blocked();
    nothing("R10 return in thumb", 7'h0, 1, mk(5'b0, 0, 1, 0, 1, M_SVC));
    nothing("R10 return with J", 7'h0, 1, mk(5'b0, 1, 1, 0, 0, M_SVC));
    nothing("R10 return in user", 7'h0, 1, mk(5'b0, 0, 0, 0, 0, M_USR));
    nothing("R10 return in system", 7'h0, 1, mk(5'b0, 0, 0, 0, 0, M_SYS));
    // entry wins over a simultaneous return
    fire(Q_IRQ, 1, 0, mk(5'b0, 0, 0, 0, 0, M_SVC), 32'h0000_4000, 32'h1111_0010, 32'h2222_0000);
    ck("R10 entry beats return pc", pc_data, 32'h18);
    ck("R10 entry beats return banks", {30'h0, spsr_we, lr_we}, 32'h3);
    idle_check("R10");
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    drive(7'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    repeat (3) @(posedge clk);
    #1 t_reset_state();
    @(negedge clk) rst_n = 1'b1;
    idle_check("R1 after reset");
    t_low_vectors();
    t_high_vectors();
    t_priority();
    t_masking();
    t_state_forced();
    t_return();
    t_return_blocked();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule